// File: doc/BRIEF.md
# Receive FIFO Interrupt Decision Logic

This block decides when a UART receiver should signal software that bytes are waiting. It watches a byte-arrival strobe and the receive FIFO occupancy, which come from a deserializer and a FIFO outside the block. It sets a sticky ready flag when the occupancy reaches a programmable threshold. It also sets the flag when bytes sit below that threshold and no new byte has arrived for fifteen character-bit periods.

The idle timeout lets a short burst, such as one keystroke on a console, be reported without waiting for the threshold to fill. The bit period is a fixed parameter, `CLKS_PER_ETU`, counted in system clock cycles. It does not follow any programmed baud rate. Software clears the flag with a one-cycle strobe. The interrupt line is the flag gated by an enable input.

Top module: `rx_irq_ctrl`

## Requirements
- R1: The threshold is chosen by `trig_sel`: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. When `fifo_count` is at or above the threshold at a clock edge, `rdy_flag` is 1 after that edge.
- R2: A byte strobe arms the idle timer when it arrives with a nonzero count that is below the threshold. If no further byte arrives and the count stays nonzero and below the threshold, `rdy_flag` rises exactly 15×`CLKS_PER_ETU` clock edges after the edge that sampled the strobe, and not before.
- R3: Every byte strobe taken below the threshold restarts the idle period from zero.
- R4: Reaching the threshold cancels a pending idle timeout. If the count then falls back below the threshold with no new byte, no timeout occurs.
- R5: A `flag_clr` pulse clears `rdy_flag` at the next edge. If the threshold is still met on that same cycle, the flag stays 1.
- R6: The idle timer does not run while `fifo_count` is 0. It fires at most once per idle period, so after a timeout and a clear, the flag stays 0 until a new byte arrives.
- R7: `rx_irq` equals `rdy_flag` AND `rx_ie`. The flag is set regardless of `rx_ie`.
- R8: While reset is asserted, and just after it is released, `rdy_flag` and `rx_irq` are 0 and no idle timeout is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_stb | input | 1 | One-cycle pulse for each byte written into the receive FIFO |
| fifo_count | input | 5 | Current receive FIFO occupancy, 0 to 16, already including a byte strobed this cycle |
| trig_sel | input | 2 | Threshold code (0:1, 1:4, 2:8, 3:14) |
| rx_ie | input | 1 | Receive interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the ready flag |
| rdy_flag | output | 1 | Sticky receive-data-ready flag |
| rx_irq | output | 1 | Level interrupt, the flag gated by `rx_ie` |

## Verification
The assertions assume that `fifo_count` already includes any byte strobed in the same cycle, that it never exceeds 16, and that a byte strobe never comes with a zero count. The bench models the FIFO occupancy itself and moves it only in ways a real FIFO could: it steps the count up with each strobe and drains it without a strobe. The idle parameter is made small so that each timeout window can be timed edge by edge.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  localparam int FIFO_DEPTH = 16;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;

  function automatic logic [CNT_W-1:0] trig_level(trig_sel_e sel);
    case (sel)
      TRIG_1:  trig_level = CNT_W'(1);
      TRIG_4:  trig_level = CNT_W'(4);
      TRIG_8:  trig_level = CNT_W'(8);
      default: trig_level = CNT_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/rxirq_trigger.sv
module rxirq_trigger
  import rxirq_pkg::*;
(
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [1:0]       trig_sel,
  output logic             thr_hit
);
  logic [CNT_W-1:0] level;

  always_comb begin
    level   = trig_level(trig_sel_e'(trig_sel));
    thr_hit = (fifo_count >= level);
  end
endmodule

// File: rtl/rxirq_idle_timer.sv
module rxirq_idle_timer #(
  parameter int LIMIT = 156255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_stb,
  input  logic fifo_empty,
  input  logic thr_hit,
  output logic fire
);
  localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic          armed_q, armed_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    armed_d = armed_q;
    tmr_d   = tmr_q;
    tmr_en  = 1'b0;
    fire    = 1'b0;
    if (thr_hit || fifo_empty) begin
      armed_d = 1'b0;
    end else if (byte_stb) begin
      armed_d = 1'b1;
      tmr_d   = '0;
      tmr_en  = 1'b1;
    end else if (armed_q) begin
      if (tmr_q == LAST) begin
        fire    = 1'b1;
        armed_d = 1'b0;
      end else begin
        tmr_d  = tmr_q + 1'b1;
        tmr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !thr_hit && !fifo_empty) |=> (armed_q && tmr_q == '0));
  // R4
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> !armed_q);
  // R6
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> !armed_q);
  // R2
  tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (tmr_q <= LAST));
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rxirq_pkg::*;
#(
  parameter int CLKS_PER_ETU    = 10417,
  parameter int ETU_PER_TIMEOUT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_stb,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [1:0]       trig_sel,
  input  logic             rx_ie,
  input  logic             flag_clr,
  output logic             rdy_flag,
  output logic             rx_irq
);
  localparam int LIMIT = CLKS_PER_ETU * ETU_PER_TIMEOUT;

  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       thr_hit;
  logic       tmo_fire;
  logic       fifo_empty;
  logic       rdy_q, rdy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign fifo_empty = (fifo_count == '0);

  rxirq_trigger u_trig (
    .fifo_count (fifo_count),
    .trig_sel   (trig_sel),
    .thr_hit    (thr_hit)
  );

  rxirq_idle_timer #(.LIMIT(LIMIT)) u_idle (
    .clk        (clk),
    .rst_n      (rst_s),
    .byte_stb   (byte_stb),
    .fifo_empty (fifo_empty),
    .thr_hit    (thr_hit),
    .fire       (tmo_fire)
  );

  always_comb begin
    rdy_d = rdy_q;
    if (flag_clr)            rdy_d = 1'b0;
    if (thr_hit || tmo_fire) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign rdy_flag = rdy_q;
  assign rx_irq   = rdy_q & rx_ie;

  // R1
  thr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    thr_hit |=> rdy_q);
  // R5
  clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (flag_clr && !thr_hit && !tmo_fire) |=> !rdy_q);
  // R2
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rdy_q) |-> $past(thr_hit || tmo_fire));
  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!rx_ie) |-> !rx_irq);
endmodule

// File: tb/tb_rx_irq_ctrl.sv
module tb_rx_irq_ctrl;
  localparam int ETU   = 4;
  localparam int LIMIT = 15 * ETU;
  localparam int NV    = 10;
  // {trig_sel, fifo_count, expected flag}
  localparam logic [7:0] VEC [NV] = '{
    {2'd0, 5'd0,  1'b0}, {2'd0, 5'd1,  1'b1},
    {2'd1, 5'd3,  1'b0}, {2'd1, 5'd4,  1'b1},
    {2'd2, 5'd7,  1'b0}, {2'd2, 5'd8,  1'b1},
    {2'd3, 5'd13, 1'b0}, {2'd3, 5'd14, 1'b1},
    {2'd3, 5'd16, 1'b1}, {2'd1, 5'd16, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_stb;
  logic [4:0] fifo_count;
  logic [1:0] trig_sel;
  logic       rx_ie;
  logic       flag_clr;
  logic       rdy_flag;
  logic       rx_irq;
  int checks = 0;
  int errors = 0;

  rx_irq_ctrl #(.CLKS_PER_ETU(ETU)) dut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .fifo_count(fifo_count),
    .trig_sel(trig_sel), .rx_ie(rx_ie), .flag_clr(flag_clr),
    .rdy_flag(rdy_flag), .rx_irq(rx_irq)
  );

  always #5 clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(logic [4:0] cnt);
    byte_stb = 1'b1;
    fifo_count = cnt;
    tick();
    byte_stb = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_stb = 1'b0; fifo_count = '0; trig_sel = 2'd3;
    rx_ie = 1'b1; flag_clr = 1'b0;
    tick(3);
    chk(rdy_flag, 1'b0, "R8 flag in reset");
    chk(rx_irq, 1'b0, "R8 irq in reset");
    rst_n = 1'b1;
    tick(4);
    chk(rdy_flag, 1'b0, "R8 flag after release");

    // R1 threshold table, R5 clear re-set, R7 gating
    for (int v = 0; v < NV; v++) begin
      trig_sel   = VEC[v][7:6];
      fifo_count = VEC[v][5:1];
      flag_clr   = 1'b1;
      tick();
      flag_clr = 1'b0;
      chk(rdy_flag, VEC[v][0], "R1 threshold");
      chk(rx_irq, VEC[v][0], "R7 irq follows flag");
    end
    // R5: clear while still above threshold keeps flag
    trig_sel = 2'd1; fifo_count = 5'd4;
    clear_flag();
    chk(rdy_flag, 1'b1, "R5 re-set on clear");
    fifo_count = 5'd0;
    clear_flag();
    chk(rdy_flag, 1'b0, "R5 clear");

    // R2 timeout exact timing, threshold 14
    trig_sel = 2'd3;
    push(5'd1);
    tick(LIMIT - 1);
    chk(rdy_flag, 1'b0, "R2 before timeout");
    tick();
    chk(rdy_flag, 1'b1, "R2 at timeout");
    chk(rx_irq, 1'b1, "R7 irq enabled");
    rx_ie = 1'b0; #1;
    chk(rx_irq, 1'b0, "R7 irq masked");
    chk(rdy_flag, 1'b1, "R7 flag kept when masked");

    // R6 single fire per idle period
    clear_flag();
    tick(2 * LIMIT);
    chk(rdy_flag, 1'b0, "R6 no second timeout");

    // R7 flag set by timeout with enable clear
    push(5'd2);
    tick(LIMIT);
    chk(rdy_flag, 1'b1, "R7 timeout with enable off");
    chk(rx_irq, 1'b0, "R7 irq off");
    rx_ie = 1'b1;
    clear_flag();

    // R3 restart on each byte
    push(5'd3);
    tick(LIMIT - 5);
    push(5'd4);
    tick(LIMIT - 1);
    chk(rdy_flag, 1'b0, "R3 restart delays timeout");
    tick();
    chk(rdy_flag, 1'b1, "R3 timeout after last byte");
    clear_flag();

    // R6 drained FIFO stops timer
    push(5'd5);
    tick(10);
    fifo_count = 5'd0;
    tick(LIMIT + 5);
    chk(rdy_flag, 1'b0, "R6 empty fifo no timeout");

    // R4 threshold cancels timeout
    trig_sel = 2'd1;
    push(5'd2);
    push(5'd4);
    chk(rdy_flag, 1'b1, "R4 threshold sets flag");
    fifo_count = 5'd2;
    clear_flag();
    chk(rdy_flag, 1'b0, "R4 cleared below threshold");
    tick(LIMIT + 5);
    chk(rdy_flag, 1'b0, "R4 timeout cancelled");

    // R8 reset aborts a pending timeout
    fifo_count = 5'd0;
    trig_sel = 2'd3;
    tick();
    push(5'd1);
    tick(5);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(LIMIT + 5);
    chk(rdy_flag, 1'b0, "R8 reset clears pending timeout");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule